// File: doc/BRIEF.md
# IDE PIO Register Access Engine

This block carries out one programmed-I/O access at a time to the register file of an IDE/ATA device. Its client hands over a five-bit register select, a read/write flag and, for writes, a 16-bit word. The engine then walks the bus through an address set-up interval, a strobe pulse and a recovery interval, all counted in clock cycles. It answers with a one-cycle completion pulse. For reads it also returns the word it sampled from the device data bus.

The register select is laid out as {chip select 1 (active low), chip select 0 (active low), A2, A1, A0}. On the task-file registers, chip select 0 is low and A2..A0 pick the register: data 0x10, feature 0x11, count 0x12, the three address bytes 0x13 to 0x15, drive/head 0x16, and command/status 0x17. The control/alternate-status register is 0x0E. Between accesses the bus rests at select 0x18, with both chip selects high and the address at zero. The data-bus output enable is raised only for writes. It stays raised past the point where the address returns to rest, so that the device sees held data.

Top module: `ide_pio_engine`

## Requirements
- R1: While reset is low, and in the first cycle after it, both strobes are high, the select outputs read 0x18 (both chip selects high, address 000), the output enable is low, done is low and the read data is zero. Reset takes effect without waiting for a clock edge.
- R2: From the cycle after a request is accepted until the strobe ends, {ide_cs1_n, ide_cs0_n, ide_addr} equals the request's select. At all other times it equals 0x18.
- R3: The select is driven for SETUP_CYC cycles with both strobes high before any strobe falls.
- R4: The strobe is low for exactly STROBE_CYC cycles. It is ide_wr_n for a write (req_write=1) and ide_rd_n for a read (req_write=0). The two strobes are never low together.
- R5: For a write, ide_doe is high and ide_dout carries the request's data from the first select cycle through the HOLD_CYC cycles after the select returns to 0x18. ide_doe falls in the done cycle.
- R6: For a read, ide_doe stays low throughout. rdata takes the value on ide_din in the last cycle the read strobe is low, and holds it until the next read completes. Writes leave it unchanged.
- R7: After the strobe rises, the select rests at 0x18 for HOLD_CYC cycles before done.
- R8: done is high for exactly one cycle, SETUP_CYC+STROBE_CYC+HOLD_CYC cycles after the first select cycle.
- R9: A request presented while an access is in progress, including the done cycle, is ignored. It changes neither the outputs nor the running access.
- R10: A request held high continuously is accepted again in the cycle after done. Its select appears SETUP_CYC+STROBE_CYC+HOLD_CYC+2 cycles after the previous access's first select cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sel | input | 5 | Register select {cs1_n, cs0_n, A2, A1, A0} |
| req_wdata | input | 16 | Data for a write access |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word sampled by the last read |
| ide_dout | output | 16 | Data toward the device |
| ide_doe | output | 1 | Output enable of the data-bus drivers |
| ide_din | input | 16 | Data from the device |
| ide_addr | output | 3 | Register address A2..A0 |
| ide_cs0_n | output | 1 | Chip select 0, active low |
| ide_cs1_n | output | 1 | Chip select 1, active low |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the engine with SETUP_CYC=3, STROBE_CYC=5 and HOLD_CYC=2. Because the three values differ, an interval swapped between phases or off by one shifts a phase boundary, and the per-cycle comparison catches the shift. The short intervals keep every access within a dozen cycles. That leaves room to compare every output in every cycle of each access, to inject ignored requests both mid-access and in the done cycle, and to measure back-to-back acceptance. The device stub drives a poison word whenever the read strobe is high, so a sample taken after the strobe rises shows up in rdata.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV,
    PH_DONE
  } pio_phase_t;

  localparam int SEL_W = 5;
  localparam int DAT_W = 16;
  localparam logic [SEL_W-1:0] SEL_REST = 5'h18;

endpackage

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (!expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ide_pio_rcap.sv
module ide_pio_rcap #(
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [DAT_W-1:0] din,
  output logic [DAT_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= din;
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC  = 6,
  parameter int STROBE_CYC = 12,
  parameter int HOLD_CYC   = 3,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [DAT_W-1:0] req_wdata,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture,
  output logic             done,
  output logic [SEL_W-1:0] sel_o,
  output logic [DAT_W-1:0] dout_o,
  output logic             doe_o,
  output logic             rd_n_o,
  output logic             wr_n_o
);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  pio_phase_t       ph_q, ph_d;
  logic             wr_q, wr_d;
  logic             accept, strobe_on, strobe_off, recov_end;
  logic [SEL_W-1:0] sel_d;
  logic [DAT_W-1:0] dout_d;
  logic             doe_d, rd_n_d, wr_n_d, done_d;

  assign accept     = (ph_q == PH_IDLE) && req_valid;
  assign strobe_on  = (ph_q == PH_SETUP) && tmr_expired;
  assign strobe_off = (ph_q == PH_STROBE) && tmr_expired;
  assign recov_end  = (ph_q == PH_RECOV) && tmr_expired;
  assign capture    = strobe_off && !wr_q;

  // next phase and timer control
  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = SETUP_LD;
    unique case (ph_q)
      PH_IDLE:   if (req_valid) begin ph_d = PH_SETUP; tmr_load = 1'b1; tmr_val = SETUP_LD; end
      PH_SETUP:  if (tmr_expired) begin ph_d = PH_STROBE; tmr_load = 1'b1; tmr_val = STROBE_LD; end
      PH_STROBE: if (tmr_expired) begin ph_d = PH_RECOV; tmr_load = 1'b1; tmr_val = HOLD_LD; end
      PH_RECOV:  if (tmr_expired) ph_d = PH_DONE;
      PH_DONE:   ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  // next bus outputs
  always_comb begin
    wr_d   = accept ? req_write : wr_q;
    sel_d  = sel_o;
    dout_d = dout_o;
    doe_d  = doe_o;
    rd_n_d = rd_n_o;
    wr_n_d = wr_n_o;
    done_d = recov_end;
    if (accept) begin
      sel_d = req_sel;
      doe_d = req_write;
      if (req_write) dout_d = req_wdata;
    end
    if (strobe_on) begin
      wr_n_d = ~wr_q;
      rd_n_d = wr_q;
    end
    if (strobe_off) begin
      wr_n_d = 1'b1;
      rd_n_d = 1'b1;
      sel_d  = SEL_REST;
    end
    if (recov_end) doe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      wr_q   <= 1'b0;
      sel_o  <= SEL_REST;
      dout_o <= '0;
      doe_o  <= 1'b0;
      rd_n_o <= 1'b1;
      wr_n_o <= 1'b1;
      done   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      wr_q   <= wr_d;
      sel_o  <= sel_d;
      dout_o <= dout_d;
      doe_o  <= doe_d;
      rd_n_o <= rd_n_d;
      wr_n_o <= wr_n_d;
      done   <= done_d;
    end
  end

  // R4: strobes are mutually exclusive
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R3: select does not change in the cycle a strobe falls
  a_r3_sel_stable_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> $stable(sel_o));

  // R6: drivers stay off while reading
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !doe_o);

  // R5: drivers still on when the write strobe rises
  a_r5_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_o) |-> doe_o);

  // R7: select at rest once the strobe has risen
  a_r7_rest_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_n_o) || $rose(rd_n_o)) |-> (sel_o == SEL_REST));

  // R8: done lasts one cycle and strobes are idle then
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n_o && wr_n_o && !doe_o));

endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine #(
  parameter int SETUP_CYC  = 6,
  parameter int STROBE_CYC = 12,
  parameter int HOLD_CYC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_sel,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic [15:0] rdata,
  output logic [15:0] ide_dout,
  output logic        ide_doe,
  input  logic [15:0] ide_din,
  output logic [2:0]  ide_addr,
  output logic        ide_cs0_n,
  output logic        ide_cs1_n,
  output logic        ide_rd_n,
  output logic        ide_wr_n
);
  import ide_pio_pkg::*;

  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ?
                         ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                         ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CNT_W = (MAX_A < 2) ? 1 : $clog2(MAX_A);

  logic             tmr_load, tmr_expired, capture;
  logic [CNT_W-1:0] tmr_val;
  logic [SEL_W-1:0] sel;

  initial begin
    if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1)
      $error("ide_pio_engine: intervals must be at least one cycle");
  end

  ide_pio_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ide_pio_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_sel     (req_sel),
    .req_wdata   (req_wdata),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .capture     (capture),
    .done        (done),
    .sel_o       (sel),
    .dout_o      (ide_dout),
    .doe_o       (ide_doe),
    .rd_n_o      (ide_rd_n),
    .wr_n_o      (ide_wr_n)
  );

  ide_pio_rcap #(.DAT_W(DAT_W)) u_rcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .din     (ide_din),
    .rdata   (rdata)
  );

  assign ide_cs1_n = sel[4];
  assign ide_cs0_n = sel[3];
  assign ide_addr  = sel[2:0];

endmodule

// File: tb/ide_pio_engine_tb.sv
module ide_pio_engine_tb;

  localparam int S = 3;
  localparam int T = 5;
  localparam int H = 2;
  localparam int L = S + T + H;
  localparam int NV = 6;

  // {write, select, write data, device word}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'h10, 16'h1234, 16'h0000},
    {1'b1, 5'h17, 16'h0020, 16'h0000},
    {1'b0, 5'h17, 16'h0000, 16'h0058},
    {1'b1, 5'h0E, 16'h0004, 16'h0000},
    {1'b0, 5'h10, 16'h0000, 16'hA5C3},
    {1'b0, 5'h0E, 16'h0000, 16'h0050}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [4:0]  req_sel;
  logic [15:0] req_wdata, dev_word;
  logic        done, ide_doe, ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n;
  logic [15:0] rdata, ide_dout, ide_din;
  logic [2:0]  ide_addr;
  logic [4:0]  bus_sel;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign ide_din = ide_rd_n ? 16'hBAD0 : dev_word;
  assign bus_sel = {ide_cs1_n, ide_cs0_n, ide_addr};

  ide_pio_engine #(.SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_wdata (req_wdata),
    .done      (done),
    .rdata     (rdata),
    .ide_dout  (ide_dout),
    .ide_doe   (ide_doe),
    .ide_din   (ide_din),
    .ide_addr  (ide_addr),
    .ide_cs0_n (ide_cs0_n),
    .ide_cs1_n (ide_cs1_n),
    .ide_rd_n  (ide_rd_n),
    .ide_wr_n  (ide_wr_n)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_rest(input string rq);
    chk(rq, "sel", 32'(bus_sel), 32'h18);
    chk(rq, "strobes", {30'd0, ide_rd_n, ide_wr_n}, 32'h3);
    chk(rq, "doe", 32'(ide_doe), 32'h0);
    chk(rq, "done", 32'(done), 32'h0);
  endtask

  // one access: cycle-by-cycle comparison with stray requests injected
  task automatic run_vec(input logic [37:0] v);
    logic        wr  = v[37];
    logic [4:0]  sel = v[36:32];
    logic [15:0] wd  = v[31:16];
    logic [15:0] prev_rdata = rdata;
    logic [15:0] seen_wr = 16'hxxxx;
    dev_word  = v[15:0];
    req_valid = 1'b1;
    req_write = wr;
    req_sel   = sel;
    req_wdata = wd;
    @(negedge clk);
    for (int k = 0; k <= L + 2; k++) begin
      bit in_s = (k < S);
      bit in_t = (k >= S) && (k < S + T);
      bit in_r = (k >= S + T) && (k < L);
      string sr = in_s ? "R3" : (in_r ? "R7" : ((k > L) ? "R9" : "R2"));
      chk(sr, "sel", 32'(bus_sel), (in_s || in_t) ? 32'(sel) : 32'h18);
      chk("R4", "wr_n", 32'(ide_wr_n), (in_t && wr) ? 32'h0 : 32'h1);
      chk("R4", "rd_n", 32'(ide_rd_n), (in_t && !wr) ? 32'h0 : 32'h1);
      chk(wr ? "R5" : "R6", "doe", 32'(ide_doe), (wr && k < L) ? 32'h1 : 32'h0);
      if (wr && k < L) chk("R5", "dout", 32'(ide_dout), 32'(wd));
      chk("R8", "done", 32'(done), (k == L) ? 32'h1 : 32'h0);
      if (!ide_wr_n) seen_wr = ide_dout;
      // stray request during the access and in the done cycle (R9)
      req_valid = (k == 1) || (k == L);
      req_write = 1'b1;
      req_sel   = 5'h0E;
      req_wdata = 16'hFFFF;
      @(negedge clk);
    end
    if (wr) begin
      chk("R5", "written word", 32'(seen_wr), 32'(wd));
      chk("R6", "rdata kept on write", 32'(rdata), 32'(prev_rdata));
    end else begin
      chk("R6", "rdata", 32'(rdata), 32'(v[15:0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_sel = 5'h18; req_wdata = '0; dev_word = '0;
    repeat (3) @(negedge clk);
    chk_rest("R1");
    chk("R1", "rdata", 32'(rdata), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_rest("R1");

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R10: request held high, next acceptance timing
    req_valid = 1'b1; req_write = 1'b0; req_sel = 5'h17; dev_word = 16'h0041;
    @(negedge clk);
    begin
      int k2 = 0;
      int gap = 0;
      for (int k = 1; k < 3 * L; k++) begin
        @(negedge clk);
        if (k > S + T && bus_sel == 5'h17 && gap == 0) gap = k;
        k2 = k;
      end
      chk("R10", "reaccept cycle", 32'(gap), 32'(L + 2));
      chk("R10", "loop ran", 32'(k2), 32'(3 * L - 1));
    end
    req_valid = 1'b0;
    repeat (2 * L) @(negedge clk);
    chk_rest("R9");

    // R1: asynchronous reset in the middle of a read strobe
    req_valid = 1'b1; req_write = 1'b0; req_sel = 5'h12;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (S + 1) @(negedge clk);
    chk("R4", "rd_n low before reset", 32'(ide_rd_n), 32'h0);
    rst_n = 1'b0;
    #1;
    chk_rest("R1");
    chk("R1", "rdata cleared", 32'(rdata), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_rest("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule